// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block turns the interrupt events of a 16550-style serial port into one interrupt line and a 4-bit identity code. Software reads the code to learn which cause needs service. Six causes are tracked, and each one has its own way of being cleared:

- receive line error
- receive data ready
- receive character timeout
- transmit holding empty
- modem line change
- busy write

When several causes are pending at once, the one with the highest priority is the one reported.

The block also runs the receive character-timeout timer. The timer counts ticks of the 16x baud clock, and its length follows the configured word length. Serial shifting, FIFO storage and the baud generator sit outside this block. They feed it FIFO levels, event pulses and one-cycle register access strobes.

The reported code is combinational from the pending state, the current FIFO level and the enables. A read strobe on the identity register acts on the code shown in that same cycle, so the clear-on-read of transmit empty only happens when transmit empty was the code reported.

Top module: `uart_irq_id`

## Requirements
- R1: Identity codes are: 4'b0001 none, 4'b0110 line error, 4'b0100 data ready, 4'b1100 timeout, 4'b0010 transmit empty, 4'b0000 modem change, 4'b0111 busy write. While reset is held and after it, the code is 4'b0001 and irq_o is 0.
- R2: A pulse on ls_err_i makes the line error cause pending from the next cycle. It stays pending until a lsr_rd_i strobe; if an error and a read arrive in the same cycle, the error wins.
- R3: Data ready is a level, not a stored event. With fifo_en_i=0 it is present while rx_level_i is non-zero. With fifo_en_i=1 it is present while rx_level_i is non-zero and at least rx_trig_i. It drops in the same cycle the level falls below that condition.
- R4: wlen_i selects the data bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8. One character time is (data bits + 2) x 16 baud ticks. With fifo_en_i=1 and a non-zero rx_level_i, the timeout becomes pending on the edge that counts the 4-character-time-th baud tick after the last push or receive read. That is 448 ticks for wlen_i=0 and 640 for wlen_i=3.
- R5: A rbr_rd_i strobe clears a pending timeout in the next cycle. A rx_push_i or rbr_rd_i restarts the timer.
- R6: Transmit empty is set when its condition rises. The condition is tx_level_i==0, or tx_level_i<=tx_thresh_i when fifo_en_i and thre_prog_i are both 1. It is cleared by a thr_wr_i strobe, by the condition going false, or by an iir_rd_i strobe while the code is 4'b0010.
- R7: An iir_rd_i strobe while any other code is shown leaves transmit empty pending.
- R8: Any bit of msr_delta_i sets the modem cause. msr_rd_i clears it; a change and a read in the same cycle leave it set.
- R9: lcr_wr_i together with busy_i sets the busy cause, which usr_rd_i clears. lcr_wr_i with busy_i=0 has no effect.
- R10: Priority from highest to lowest is line error, then data ready / timeout, then transmit empty, then modem, then busy. Data ready is reported over timeout.
- R11: ien_i masks causes: bit 0 data ready and timeout, bit 1 transmit empty, bit 2 line error, bit 3 modem. Busy cannot be masked. Masked causes stay pending but are not reported. irq_o is 1 exactly when the code is not 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode enable |
| thre_prog_i | input | 1 | Threshold-based transmit empty mode |
| ien_i | input | 4 | Cause enables (see R11) |
| wlen_i | input | 2 | Word length code |
| baud_tick_i | input | 1 | 16x baud tick |
| ls_err_i | input | 1 | Overrun, parity, framing or break event |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_trig_i | input | LVL_W | Receive trigger level |
| rx_push_i | input | 1 | Character written into receive FIFO |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| tx_thresh_i | input | LVL_W | Transmit empty threshold |
| thr_wr_i | input | 1 | Transmit holding write strobe |
| msr_delta_i | input | 4 | Modem line change pulses |
| lcr_wr_i | input | 1 | Line control write strobe |
| busy_i | input | 1 | Port busy flag |
| lsr_rd_i | input | 1 | Line status read strobe |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| iir_rd_i | input | 1 | Identity register read strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| usr_rd_i | input | 1 | Port status read strobe |
| irq_o | output | 1 | Interrupt request |
| iid_o | output | 4 | Identity code |

## Verification
Some properties are checked on every cycle:
- the code is always a legal value and always agrees with irq_o
- a line error is reported on the very next cycle
- a transmit write, modem read or receive read clears its cause on the following cycle
- a reported busy cause keeps irq_o high until the status read

Other behaviour depends on exact cycle counts and mixed histories, so only the bench scenarios can show it:
- the timeout length for each word length, and the timer restart on a push
- a masked cause staying pending
- transmit empty surviving an identity read that reported another cause
- the full priority order under random stimulus

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    IID_MSI  = 4'b0000,
    IID_NONE = 4'b0001,
    IID_THRE = 4'b0010,
    IID_RDA  = 4'b0100,
    IID_RLS  = 4'b0110,
    IID_BUSY = 4'b0111,
    IID_CTO  = 4'b1100
  } iid_e;

  typedef struct packed {
    logic rls;
    logic rda;
    logic cto;
    logic thre;
    logic msi;
    logic busy;
  } src_t;

  localparam int IEN_RX = 0;
  localparam int IEN_TX = 1;
  localparam int IEN_LS = 2;
  localparam int IEN_MS = 3;
  localparam int IEN_W  = 4;
  localparam int MSR_W  = 4;
endpackage

// File: rtl/uart_irq_timer.sv
module uart_irq_timer #(
  parameter int LVL_W      = 5,
  parameter int OVERSAMPLE = 16,
  parameter int TO_CHARS   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             rx_push_i,
  input  logic             rbr_rd_i,
  input  logic             baud_tick_i,
  input  logic [1:0]       wlen_i,
  output logic             cto_o
);
  localparam int MAX_LIM = TO_CHARS * OVERSAMPLE * 10;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic [CNT_W-1:0] cnt_q, limit;
  logic             cto_q, idle, armed;

  // start + data + stop, in oversample ticks, times the char count
  always_comb begin
    limit = CNT_W'(TO_CHARS * OVERSAMPLE * (int'(wlen_i) + 7));
    armed = fifo_en_i && (rx_level_i != '0);
    idle  = armed && !rx_push_i && !rbr_rd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!idle || cto_q) begin
      cnt_q <= '0;
    end else if (baud_tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cto_q <= 1'b0;
    end else if (rbr_rd_i || !armed) begin
      cto_q <= 1'b0;
    end else if (idle && baud_tick_i && (cnt_q >= limit - CNT_W'(1))) begin
      cto_q <= 1'b1;
    end
  end

  assign cto_o = cto_q;
endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             thre_prog_i,
  input  logic             ls_err_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] tx_thresh_i,
  input  logic             thr_wr_i,
  input  logic [MSR_W-1:0] msr_delta_i,
  input  logic             lcr_wr_i,
  input  logic             busy_i,
  input  logic             lsr_rd_i,
  input  logic             iir_rd_i,
  input  logic             msr_rd_i,
  input  logic             usr_rd_i,
  input  logic             cto_i,
  input  iid_e             code_i,
  output src_t             pend_o
);
  logic rls_q, thre_q, msi_q, busy_q, tcond_q;
  logic tcond, trise, tclr, rda, any_delta;

  // one OR term per modem line
  logic [MSR_W-1:0] delta_or;
  for (genvar g = 0; g < MSR_W; g++) begin : g_delta
    if (g == 0) begin : g_first
      assign delta_or[g] = msr_delta_i[g];
    end else begin : g_rest
      assign delta_or[g] = delta_or[g-1] | msr_delta_i[g];
    end
  end
  assign any_delta = delta_or[MSR_W-1];

  always_comb begin
    if (fifo_en_i) rda = (rx_level_i != '0) && (rx_level_i >= rx_trig_i);
    else           rda = (rx_level_i != '0);
    if (fifo_en_i && thre_prog_i) tcond = (tx_level_i <= tx_thresh_i);
    else                          tcond = (tx_level_i == '0);
    trise = tcond && !tcond_q && !thr_wr_i;
    tclr  = thr_wr_i || !tcond || (iir_rd_i && (code_i == IID_THRE));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rls_q   <= 1'b0;
      thre_q  <= 1'b0;
      msi_q   <= 1'b0;
      busy_q  <= 1'b0;
      tcond_q <= 1'b1;
    end else begin
      rls_q   <= ls_err_i | (rls_q & ~lsr_rd_i);
      msi_q   <= any_delta | (msi_q & ~msr_rd_i);
      busy_q  <= (lcr_wr_i & busy_i) | (busy_q & ~usr_rd_i);
      thre_q  <= (thre_q & ~tclr) | trise;
      tcond_q <= tcond;
    end
  end

  always_comb begin
    pend_o.rls  = rls_q;
    pend_o.rda  = rda;
    pend_o.cto  = cto_i;
    pend_o.thre = thre_q;
    pend_o.msi  = msi_q;
    pend_o.busy = busy_q;
  end
endmodule

// File: rtl/uart_irq_enc.sv
module uart_irq_enc
  import uart_irq_pkg::*;
(
  input  src_t             pend_i,
  input  logic [IEN_W-1:0] ien_i,
  output iid_e             code_o,
  output logic             irq_o
);
  src_t act;

  always_comb begin
    act.rls  = pend_i.rls  & ien_i[IEN_LS];
    act.rda  = pend_i.rda  & ien_i[IEN_RX];
    act.cto  = pend_i.cto  & ien_i[IEN_RX];
    act.thre = pend_i.thre & ien_i[IEN_TX];
    act.msi  = pend_i.msi  & ien_i[IEN_MS];
    act.busy = pend_i.busy;
    irq_o    = |act;
    if      (act.rls)  code_o = IID_RLS;
    else if (act.rda)  code_o = IID_RDA;
    else if (act.cto)  code_o = IID_CTO;
    else if (act.thre) code_o = IID_THRE;
    else if (act.msi)  code_o = IID_MSI;
    else if (act.busy) code_o = IID_BUSY;
    else               code_o = IID_NONE;
  end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int LVL_W      = 5,
  parameter int OVERSAMPLE = 16,
  parameter int TO_CHARS   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             thre_prog_i,
  input  logic [3:0]       ien_i,
  input  logic [1:0]       wlen_i,
  input  logic             baud_tick_i,
  input  logic             ls_err_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  input  logic             rx_push_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] tx_thresh_i,
  input  logic             thr_wr_i,
  input  logic [3:0]       msr_delta_i,
  input  logic             lcr_wr_i,
  input  logic             busy_i,
  input  logic             lsr_rd_i,
  input  logic             rbr_rd_i,
  input  logic             iir_rd_i,
  input  logic             msr_rd_i,
  input  logic             usr_rd_i,
  output logic             irq_o,
  output logic [3:0]       iid_o
);
  logic cto;
  src_t pend;
  iid_e code;

  uart_irq_timer #(
    .LVL_W(LVL_W), .OVERSAMPLE(OVERSAMPLE), .TO_CHARS(TO_CHARS)
  ) u_timer (
    .clk_i, .rst_ni, .fifo_en_i, .rx_level_i, .rx_push_i, .rbr_rd_i,
    .baud_tick_i, .wlen_i, .cto_o(cto)
  );

  uart_irq_src #(.LVL_W(LVL_W)) u_src (
    .clk_i, .rst_ni, .fifo_en_i, .thre_prog_i, .ls_err_i, .rx_level_i,
    .rx_trig_i, .tx_level_i, .tx_thresh_i, .thr_wr_i, .msr_delta_i,
    .lcr_wr_i, .busy_i, .lsr_rd_i, .iir_rd_i, .msr_rd_i, .usr_rd_i,
    .cto_i(cto), .code_i(code), .pend_o(pend)
  );

  uart_irq_enc u_enc (
    .pend_i(pend), .ien_i(ien_i), .code_o(code), .irq_o(irq_o)
  );

  assign iid_o = code;
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       ien_i,
  input logic             ls_err_i,
  input logic [LVL_W-1:0] rx_level_i,
  input logic             thr_wr_i,
  input logic [3:0]       msr_delta_i,
  input logic             rbr_rd_i,
  input logic             msr_rd_i,
  input logic             usr_rd_i,
  input logic             irq_o,
  input logic [3:0]       iid_o
);
  AST_IID_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iid_o inside {4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b0110, 4'b0111, 4'b1100}); // R1
  AST_IRQ_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iid_o != 4'b0001)); // R11
  AST_RLS_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_err_i |=> (!ien_i[2] || iid_o == 4'b0110)); // R2
  AST_RDA_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iid_o == 4'b0100) |-> (rx_level_i != '0)); // R3
  AST_CTO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbr_rd_i |=> (iid_o != 4'b1100)); // R5
  AST_THRE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> (iid_o != 4'b0010)); // R6
  AST_MSI_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_rd_i && msr_delta_i == 4'b0000) |=> (iid_o != 4'b0000)); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iid_o == 4'b0111 && !usr_rd_i) |=> irq_o); // R9
endmodule

bind uart_irq_id uart_irq_id_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i, .rst_ni, .ien_i, .ls_err_i, .rx_level_i, .thr_wr_i, .msr_delta_i,
  .rbr_rd_i, .msr_rd_i, .usr_rd_i, .irq_o, .iid_o
);

// File: tb/sim_uart_irq_id.sv
module sim_uart_irq_id;
  localparam int LVL_W = 5;
  localparam int L5 = 448;
  localparam int L8 = 640;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fifo_en, thre_prog, baud_tick, ls_err, rx_push, thr_wr, lcr_wr, busy;
  logic lsr_rd, rbr_rd, iir_rd, msr_rd, usr_rd, irq;
  logic [3:0] ien, msr_delta, iid;
  logic [1:0] wlen;
  logic [LVL_W-1:0] rx_level, rx_trig, tx_level, tx_thresh;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  uart_irq_id #(.LVL_W(LVL_W)) u0 (
    .clk_i(clk), .rst_ni, .fifo_en_i(fifo_en), .thre_prog_i(thre_prog), .ien_i(ien),
    .wlen_i(wlen), .baud_tick_i(baud_tick), .ls_err_i(ls_err), .rx_level_i(rx_level),
    .rx_trig_i(rx_trig), .rx_push_i(rx_push), .tx_level_i(tx_level),
    .tx_thresh_i(tx_thresh), .thr_wr_i(thr_wr), .msr_delta_i(msr_delta),
    .lcr_wr_i(lcr_wr), .busy_i(busy), .lsr_rd_i(lsr_rd), .rbr_rd_i(rbr_rd),
    .iir_rd_i(iir_rd), .msr_rd_i(msr_rd), .usr_rd_i(usr_rd), .irq_o(irq), .iid_o(iid)
  );

  // bench-side model of pending causes
  logic m_rls, m_msi, m_busy, m_thre, m_tcond_q;

  function automatic logic [3:0] exp_code();
    logic rda;
    rda = fifo_en ? (rx_level != 0 && rx_level >= rx_trig) : (rx_level != 0);
    if (m_rls && ien[2])       return 4'b0110;
    else if (rda && ien[0])    return 4'b0100;
    else if (m_thre && ien[1]) return 4'b0010;
    else if (m_msi && ien[3])  return 4'b0000;
    else if (m_busy)           return 4'b0111;
    return 4'b0001;
  endfunction

  task automatic chk(string r, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s iid act=%b exp=%b", r, act, exp);
    end
  endtask

  task automatic chk_irq(string r, logic exp);
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s irq act=%b exp=%b", r, irq, exp);
    end
  endtask

  task automatic clear_strobes();
    ls_err = 0; rx_push = 0; thr_wr = 0; lcr_wr = 0; msr_delta = 0;
    lsr_rd = 0; rbr_rd = 0; iir_rd = 0; msr_rd = 0; usr_rd = 0;
  endtask

  // strobes set before this are sampled on the next edge, then dropped
  task automatic pulse();
    @(negedge clk);
    clear_strobes();
    #1;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_strobes();
    fifo_en = 0; thre_prog = 0; ien = 4'hF; wlen = 0; baud_tick = 0; busy = 0;
    rx_level = 0; rx_trig = 1; tx_level = 0; tx_thresh = 0;
    #5;
    chk("R1 reset", iid, 4'b0001); chk_irq("R1 reset", 1'b0);
    @(negedge clk); rst_ni = 1;
    waitn(1);
    chk("R1 after reset", iid, 4'b0001); chk_irq("R1 after reset", 1'b0);

    // busy write
    @(negedge clk); lcr_wr = 1; busy = 0; pulse();
    chk("R9 no busy ignored", iid, 4'b0001);
    @(negedge clk); lcr_wr = 1; busy = 1; pulse(); busy = 0;
    chk("R9 busy set", iid, 4'b0111); chk_irq("R9", 1'b1);
    @(negedge clk); msr_delta = 4'b0100; pulse();
    chk("R10 modem over busy", iid, 4'b0000);
    @(negedge clk); msr_rd = 1; msr_delta = 4'b0001; pulse();
    chk("R8 change wins read", iid, 4'b0000);
    @(negedge clk); msr_rd = 1; pulse();
    chk("R8 modem cleared", iid, 4'b0111);
    @(negedge clk); usr_rd = 1; pulse();
    chk("R9 busy cleared", iid, 4'b0001);

    // data ready, non-FIFO
    @(negedge clk); rx_level = 1; #1;
    chk("R3 data nonfifo", iid, 4'b0100);
    @(negedge clk); ls_err = 1; pulse();
    chk("R10 line err top", iid, 4'b0110);
    @(negedge clk); lsr_rd = 1; ls_err = 1; pulse();
    chk("R2 err wins read", iid, 4'b0110);
    @(negedge clk); lsr_rd = 1; pulse();
    chk("R2 line err cleared", iid, 4'b0100);
    @(negedge clk); rx_level = 0; #1;
    chk("R3 data gone", iid, 4'b0001);

    // data ready, FIFO trigger
    @(negedge clk); fifo_en = 1; rx_trig = 4; rx_level = 3; #1;
    chk("R3 below trig", iid, 4'b0001);
    @(negedge clk); rx_level = 4; #1;
    chk("R3 at trig", iid, 4'b0100);
    @(negedge clk); ien = 4'b1110; #1;
    chk("R11 masked", iid, 4'b0001); chk_irq("R11 masked", 1'b0);
    @(negedge clk); lcr_wr = 1; busy = 1; pulse(); busy = 0;
    chk("R11 busy unmasked", iid, 4'b0111); chk_irq("R11 busy", 1'b1);
    @(negedge clk); usr_rd = 1; ien = 4'hF; pulse();
    chk("R11 unmask pending", iid, 4'b0100);
    @(negedge clk); rx_level = 0; rbr_rd = 1; pulse();
    chk("R3 drained", iid, 4'b0001);

    // transmit empty
    @(negedge clk); tx_level = 3; waitn(1);
    @(negedge clk); tx_level = 0; waitn(1);
    chk("R6 empty set", iid, 4'b0010);
    @(negedge clk); thr_wr = 1; pulse();
    chk("R6 write clears", iid, 4'b0001);
    @(negedge clk); tx_level = 2; waitn(1);
    @(negedge clk); tx_level = 0; waitn(1);
    chk("R6 empty again", iid, 4'b0010);
    @(negedge clk); ls_err = 1; pulse();
    @(negedge clk); iir_rd = 1; pulse();
    chk("R7 other reported", iid, 4'b0110);
    @(negedge clk); lsr_rd = 1; pulse();
    chk("R7 thre kept", iid, 4'b0010);
    @(negedge clk); iir_rd = 1; pulse();
    chk("R6 iir read clears", iid, 4'b0001);
    @(negedge clk); thre_prog = 1; tx_thresh = 2; tx_level = 5; waitn(1);
    @(negedge clk); tx_level = 2; waitn(1);
    chk("R6 at threshold", iid, 4'b0010);
    @(negedge clk); tx_level = 3; waitn(1);
    chk("R6 above threshold", iid, 4'b0001);
    @(negedge clk); thre_prog = 0; tx_level = 0; thr_wr = 1; pulse();
    chk("R6 quiet", iid, 4'b0001);

    // character timeout
    @(negedge clk); rx_trig = 8; rx_level = 1; wlen = 0; baud_tick = 1; rx_push = 1;
    pulse();
    waitn(L5 - 1);
    chk("R4 5bit one short", iid, 4'b0001);
    waitn(1);
    chk("R4 5bit timeout", iid, 4'b1100);
    @(negedge clk); rx_level = 8; #1;
    chk("R10 data over timeout", iid, 4'b0100);
    @(negedge clk); rx_level = 1; #1;
    chk("R10 timeout back", iid, 4'b1100);
    @(negedge clk); rbr_rd = 1; pulse();
    chk("R5 read clears", iid, 4'b0001);
    waitn(99);
    @(negedge clk); rx_push = 1; wlen = 3; pulse();
    waitn(L8 - 1);
    chk("R5 push restart", iid, 4'b0001);
    waitn(1);
    chk("R4 8bit timeout", iid, 4'b1100);
    @(negedge clk); rbr_rd = 1; rx_level = 0; baud_tick = 0; fifo_en = 0; pulse();
    chk("R5 cleared", iid, 4'b0001);

    // random priority run
    void'($urandom(32'd1234));
    @(negedge clk); rst_ni = 0; #1; rst_ni = 1;
    m_rls = 0; m_msi = 0; m_busy = 0; m_thre = 0; m_tcond_q = 1;
    for (int i = 0; i < 600; i++) begin
      logic [3:0] e;
      logic tc;
      @(negedge clk);
      ls_err = ($urandom % 9 == 0); lsr_rd = ($urandom % 5 == 0);
      msr_delta = ($urandom % 8 == 0) ? 4'($urandom) : 4'h0;
      msr_rd = ($urandom % 5 == 0);
      lcr_wr = ($urandom % 8 == 0); busy = $urandom % 2; usr_rd = ($urandom % 6 == 0);
      thr_wr = ($urandom % 7 == 0); iir_rd = ($urandom % 3 == 0);
      fifo_en = $urandom % 2; thre_prog = $urandom % 2;
      rx_level = LVL_W'($urandom % 17); rx_trig = LVL_W'(1 + $urandom % 8);
      tx_level = LVL_W'($urandom % 4); tx_thresh = LVL_W'($urandom % 3);
      if (i % 16 == 0) ien = 4'($urandom);
      #1;
      e = exp_code();
      chk("R10 random", iid, e);
      chk_irq("R11 random", e != 4'b0001);
      tc = (fifo_en && thre_prog) ? (tx_level <= tx_thresh) : (tx_level == 0);
      m_thre = (m_thre && !(thr_wr || !tc || (iir_rd && e == 4'b0010)))
               || (tc && !m_tcond_q && !thr_wr);
      m_tcond_q = tc;
      m_rls = ls_err || (m_rls && !lsr_rd);
      m_msi = (msr_delta != 0) || (m_msi && !msr_rd);
      m_busy = (lcr_wr && busy) || (m_busy && !usr_rd);
    end
    @(negedge clk); clear_strobes();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule